// File: doc/BRIEF.md
# Ping-Pong PLL Frequency-Scaling Sequencer

This controller retunes a CPU clock that can run from either of two PLLs with the same set of rates. A glitch-free two-input mux picks the PLL. A rate-change request carries an integer target in MHz. The sequencer never touches the PLL that is driving the CPU. It sends the new rate to the other, idle PLL, then waits for that PLL to report lock. It lets the PLL settle for a fixed time and only then flips the mux select, so the CPU moves to the freshly tuned source in one step.

A bus clock is derived from the CPU clock by an integer divider, and the sequencer also owns that divisor. The divisor is the CPU rate divided by the bus ceiling, rounded up and then clamped. When the rate rises, the divisor is raised before the switch, so the bus never exceeds its ceiling. When the rate falls, the divisor is lowered only after the switch. If the idle PLL fails to lock in time, the request is abandoned: the select and the divisor stay as they were before the request, and the error flag is raised together with done.

Top module: `pll_pingpong_seq`

## Requirements
- R1: After reset, muxSel is 0 (PLL 0 drives the CPU), busDiv is 2, busy is 0, done is 0 and error is 0. The current rate is taken as 0 MHz.
- R2: A request accepted while idle raises pllProgEn for exactly one cycle, in the cycle after reqValid is sampled. Bit i of pllProgEn addresses PLL i, and only the bit of the PLL not selected by muxSel is set. pllProgRate carries the requested rate. The selected PLL is never programmed.
- R3: Let E be the first rising edge at which the programmed PLL's lock input is sampled high. muxSel toggles at edge E + SETTLE_US*CYC_PER_US + 1, and never earlier.
- R4: busDiv is always ceil(rate / BUS_MAX_MHZ) clamped to the range 2 to 2^DIV_W. For example, with BUS_MAX_MHZ=750 and DIV_W=3, 1500 gives 2, 1501 gives 3, 100 gives 2 and 7000 gives 8.
- R5: When the target is above the current rate, busDiv takes the value for the target in the cycle after the pllProgEn pulse, while muxSel still holds the old PLL. It keeps that value after the switch.
- R6: When the target is below the current rate, busDiv keeps its old value until the edge at which muxSel toggles, and takes the target's value at that same edge.
- R7: When the target equals the current rate, the idle PLL is still programmed and selected, and busDiv does not change.
- R8: If lock is not seen within LOCK_TIMEOUT_US*CYC_PER_US cycles of waiting, done and error are raised together for one cycle. This happens LOCK_TIMEOUT_US*CYC_PER_US+1 cycles after the pllProgEn cycle. muxSel is unchanged, and busDiv is back to its value from before the request.
- R9: busy is high from the cycle after acceptance through the done cycle and low after it. done lasts one cycle. A reqValid seen while busy is ignored: it causes no extra pllProgEn pulse and has no effect on the result.
- R10: On success, done is raised with error low in the same cycle in which the new muxSel value first appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Rate-change request strobe |
| reqRate | input | RATE_W | Requested CPU rate in MHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Lock timeout, valid with done |
| pllProgEn | output | 2 | One-cycle program strobe, bit i for PLL i |
| pllProgRate | output | RATE_W | Rate to program into the strobed PLL |
| pllLocked | input | 2 | Lock indication of each PLL |
| muxSel | output | 1 | Glitch-free mux select (PLL index) |
| busDiv | output | DIV_W+1 | Bus clock divisor |

## Verification
Each result has a fixed latency, and the checks sample on falling edges at exactly that cycle. The program strobe is due one cycle after the request. The early divisor change for a rate increase is due one cycle after the strobe. The select toggle and the done pulse are due SETTLE_US*CYC_PER_US+2 falling edges after the first falling edge at which the bench's PLL model shows lock. On a timeout, done and error are due LOCK_TIMEOUT_US*CYC_PER_US+1 cycles after the strobe. The bench counts falling edges between these events and compares the count with the exact figure. It does not wait for a flag and accept the result whenever it arrives, so an early or late switch is reported.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_LOCK,
    ST_SETTLE,
    ST_SWITCH,
    ST_FIN
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture target, save divisor
    logic preDiv;    // raise divisor ahead of an upward switch
    logic commit;    // flip mux, adopt rate, settle divisor
    logic restore;   // abandon: put saved divisor back
  } seqStb_t;

endpackage

// File: rtl/pps_datapath.sv
module pps_datapath
  import pps_pkg::*;
#(
  parameter int RATE_W      = 13,
  parameter int DIV_W       = 3,
  parameter int BUS_MAX_MHZ = 750
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] reqRate,
  input  seqStb_t           stb,
  output logic              muxSel,
  output logic [DIV_W:0]    busDiv,
  output logic [RATE_W-1:0] progRate,
  output logic              scaleUp,
  output logic              sameRate
);
  localparam int DIV_MIN = 2;
  localparam int DIV_MAX = 1 << DIV_W;

  logic [RATE_W-1:0] curRate, target;
  logic [DIV_W:0]    savedDiv, newDiv;

  always_comb begin
    int unsigned quo;
    quo = (32'(target) + 32'(BUS_MAX_MHZ) - 32'd1) / 32'(BUS_MAX_MHZ);
    if (quo < 32'(DIV_MIN))      quo = 32'(DIV_MIN);
    else if (quo > 32'(DIV_MAX)) quo = 32'(DIV_MAX);
    newDiv = (DIV_W+1)'(quo);
  end

  assign scaleUp  = target > curRate;
  assign sameRate = target == curRate;
  assign progRate = target;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      muxSel   <= 1'b0;
      curRate  <= '0;
      target   <= '0;
      busDiv   <= (DIV_W+1)'(DIV_MIN);
      savedDiv <= (DIV_W+1)'(DIV_MIN);
    end else begin
      if (stb.latchReq) begin
        target   <= reqRate;
        savedDiv <= busDiv;
      end
      if (stb.preDiv)  busDiv <= newDiv;
      if (stb.restore) busDiv <= savedDiv;
      if (stb.commit) begin
        muxSel  <= ~muxSel;
        curRate <= target;
        if (!sameRate) busDiv <= newDiv;
      end
    end
  end
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
  import pps_pkg::*;
#(
  parameter int CYC_PER_US      = 2,
  parameter int LOCK_TIMEOUT_US = 44,
  parameter int SETTLE_US       = 30
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    idleLocked,
  input  logic    scaleUp,
  output seqStb_t stb,
  output logic    progStrobe,
  output logic    busy,
  output logic    done,
  output logic    error
);
  localparam int LOCK_CYC   = LOCK_TIMEOUT_US * CYC_PER_US;
  localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
  localparam int CNT_MAX    = (LOCK_CYC > SETTLE_CYC) ? LOCK_CYC : SETTLE_CYC;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] cnt;
  logic errFlag, lockTimeout;

  assign lockTimeout = (state == ST_WAIT_LOCK) && !idleLocked &&
                       (cnt == CNT_W'(LOCK_CYC - 1));

  always_comb begin
    stb          = '0;
    stb.latchReq = (state == ST_IDLE) && reqValid;
    stb.preDiv   = (state == ST_PROG) && scaleUp;
    stb.commit   = (state == ST_SWITCH);
    stb.restore  = lockTimeout;
    progStrobe   = (state == ST_PROG);
    busy         = (state != ST_IDLE);
    done         = (state == ST_FIN);
    error        = done && errFlag;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:      if (reqValid) nextState = ST_PROG;
      ST_PROG:      nextState = ST_WAIT_LOCK;
      ST_WAIT_LOCK: if (idleLocked) nextState = ST_SETTLE;
                    else if (lockTimeout) nextState = ST_FIN;
      ST_SETTLE:    if (cnt == CNT_W'(SETTLE_CYC - 1)) nextState = ST_SWITCH;
      ST_SWITCH:    nextState = ST_FIN;
      ST_FIN:       nextState = ST_IDLE;
      default:      nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      errFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (state != nextState) cnt <= '0;
      else                    cnt <= cnt + 1'b1;
      if (stb.latchReq)     errFlag <= 1'b0;
      else if (lockTimeout) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/pll_pingpong_seq.sv
module pll_pingpong_seq
  import pps_pkg::*;
#(
  parameter int RATE_W          = 13,
  parameter int DIV_W           = 3,
  parameter int BUS_MAX_MHZ     = 750,
  parameter int CYC_PER_US      = 2,
  parameter int LOCK_TIMEOUT_US = 44,
  parameter int SETTLE_US       = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [RATE_W-1:0] reqRate,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [1:0]        pllProgEn,
  output logic [RATE_W-1:0] pllProgRate,
  input  logic [1:0]        pllLocked,
  output logic              muxSel,
  output logic [DIV_W:0]    busDiv
);
  seqStb_t stb;
  logic progStrobe, scaleUp, sameRate, idleLocked;

  assign idleLocked = pllLocked[~muxSel];

  for (genvar i = 0; i < 2; i++) begin : g_prog
    assign pllProgEn[i] = progStrobe && (muxSel != i[0]);
  end

  pps_ctrl #(
    .CYC_PER_US(CYC_PER_US), .LOCK_TIMEOUT_US(LOCK_TIMEOUT_US), .SETTLE_US(SETTLE_US)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .idleLocked(idleLocked),
    .scaleUp(scaleUp), .stb(stb), .progStrobe(progStrobe),
    .busy(busy), .done(done), .error(error)
  );

  pps_datapath #(
    .RATE_W(RATE_W), .DIV_W(DIV_W), .BUS_MAX_MHZ(BUS_MAX_MHZ)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqRate(reqRate), .stb(stb), .muxSel(muxSel),
    .busDiv(busDiv), .progRate(pllProgRate), .scaleUp(scaleUp), .sameRate(sameRate)
  );
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int DIV_W = 3
) (
  input logic           clk,
  input logic           rstN,
  input logic           busy,
  input logic           done,
  input logic           error,
  input logic [1:0]     pllProgEn,
  input logic           muxSel,
  input logic [DIV_W:0] busDiv
);
  localparam int DIV_MAX = 1 << DIV_W;

  // R10: the select only moves in a successful done cycle
  assert_switch_with_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(muxSel) |-> (done && !error));

  // R8: an abort keeps the select
  assert_abort_keeps_sel_R8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (done && $stable(muxSel)));

  // R4: divisor within its clamp range
  assert_div_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busDiv >= 2) && (32'(busDiv) <= DIV_MAX));

  // R9: busy drops right after done
  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R9: programming only happens inside a sequence
  assert_prog_in_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pllProgEn != 2'b00) |-> busy);

  // R2: at most one PLL strobed; no switch right after programming
  assert_prog_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pllProgEn));
  assert_no_early_switch_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pllProgEn != 2'b00) |=> $stable(muxSel));
endmodule

bind pll_pingpong_seq pps_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .error(error),
  .pllProgEn(pllProgEn), .muxSel(muxSel), .busDiv(busDiv)
);

// File: tb/tb_pll_pingpong_seq.sv
module tb_pll_pingpong_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RATE_W = 13;
  localparam int DIV_W = 3;
  localparam int CYC_PER_US = 2;
  localparam int LOCK_CYC = 44 * CYC_PER_US;
  localparam int SETTLE_CYC = 30 * CYC_PER_US;
  localparam int LOCK_DELAY = 10;

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic [RATE_W-1:0] reqRate = '0;
  logic busy, done, error, muxSel;
  logic [1:0] pllProgEn, pllLocked;
  logic [RATE_W-1:0] pllProgRate;
  logic [DIV_W:0] busDiv;

  int checks = 0, fails = 0, progPulses = 0;
  int mRate = 0, mDiv = 2;
  bit mSel = 1'b0, neverLock = 1'b0;
  int lockCnt [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_pingpong_seq #(.RATE_W(RATE_W), .DIV_W(DIV_W), .CYC_PER_US(CYC_PER_US)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRate(reqRate),
    .busy(busy), .done(done), .error(error), .pllProgEn(pllProgEn),
    .pllProgRate(pllProgRate), .pllLocked(pllLocked), .muxSel(muxSel), .busDiv(busDiv)
  );

  // PLL model: lock drops on programming, returns LOCK_DELAY cycles later
  initial begin pllLocked = 2'b11; lockCnt[0] = 0; lockCnt[1] = 0; end
  always @(posedge clk) begin
    if (pllProgEn != 2'b00) progPulses <= progPulses + 1;
    for (int i = 0; i < 2; i++) begin
      if (pllProgEn[i]) begin
        pllLocked[i] <= 1'b0;
        lockCnt[i]   <= neverLock ? 0 : LOCK_DELAY;
      end else if (lockCnt[i] != 0) begin
        lockCnt[i] <= lockCnt[i] - 1;
        if (lockCnt[i] == 1) pllLocked[i] <= 1'b1;
      end
    end
  end

  function automatic int expDiv(input int rate);
    int q = (rate + 749) / 750;
    if (q < 2) q = 2;
    if (q > 8) q = 8;
    return q;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // generic sequence with cycle-exact sampling
  task automatic doReq(input int rate, input bit stray, input string rq);
    int oldDiv = mDiv;
    bit oldSel = mSel;
    int nd = expDiv(rate);
    bit up = rate > mRate;
    int n, pulses0;
    pulses0 = progPulses;
    @(negedge clk); reqValid = 1'b1; reqRate = RATE_W'(rate);
    @(negedge clk); reqValid = 1'b0;
    check(pllProgEn == (oldSel ? 2'b01 : 2'b10), "R2", "idle PLL strobe",
          pllProgEn, oldSel ? 1 : 2);
    check(pllProgRate == RATE_W'(rate), "R2", "program rate", pllProgRate, rate);
    @(negedge clk);
    if (stray) begin reqValid = 1'b1; reqRate = RATE_W'(7000); end
    check(busDiv == (DIV_W+1)'(up ? nd : oldDiv), up ? "R5" : "R6",
          "divisor before switch", busDiv, up ? nd : oldDiv);
    check(muxSel == oldSel && busy, "R9", "busy, old select held", muxSel, oldSel);
    @(negedge clk); reqValid = 1'b0;
    n = 0;
    while (!pllLocked[!oldSel] && n < 500) begin @(negedge clk); n++; end
    n = 0;
    while (muxSel == oldSel && n < 500) begin
      if (n < SETTLE_CYC && busDiv != (DIV_W+1)'(up ? nd : oldDiv))
        check(0, "R6", "divisor moved before switch", busDiv, up ? nd : oldDiv);
      @(negedge clk); n++;
    end
    check(n == SETTLE_CYC + 2, "R3", "lock-to-switch cycles", n, SETTLE_CYC + 2);
    check(done && !error, "R10", "done with new select", {done, error}, 2);
    check(busDiv == (DIV_W+1)'((rate != mRate) ? nd : oldDiv),
          (rate == mRate) ? "R7" : "R4", "final divisor", busDiv,
          (rate != mRate) ? nd : oldDiv);
    @(negedge clk);
    check(!done && !busy, "R9", "idle after done", {done, busy}, 0);
    check(progPulses - pulses0 == 1, "R9", "program pulses", progPulses - pulses0, 1);
    mRate = rate; mSel = !oldSel;
    if (rate != mRate) mDiv = nd;
    mDiv = 32'(busDiv) == nd ? nd : mDiv;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(muxSel == 1'b0, "R1", "reset select", muxSel, 0);
    check(busDiv == 2, "R1", "reset divisor", busDiv, 2);
    check(!busy && !done && !error, "R1", "reset flags", {busy, done, error}, 0);
  endtask

  task automatic testScaleUp();      doReq(2000, 1'b0, "R5"); endtask
  task automatic testScaleDown();    doReq(800,  1'b0, "R6"); endtask
  task automatic testClampHigh();    doReq(7000, 1'b0, "R4"); endtask
  task automatic testSameRate();     doReq(7000, 1'b0, "R7"); endtask
  task automatic testClampLow();     doReq(100,  1'b0, "R4"); endtask
  task automatic testRoundUp();      doReq(1501, 1'b0, "R4"); endtask
  task automatic testIgnoreBusy();   doReq(2500, 1'b1, "R9"); endtask

  task automatic testTimeout();
    int oldDiv = mDiv;
    bit oldSel = mSel;
    int n = 0;
    neverLock = 1'b1;
    @(negedge clk); reqValid = 1'b1; reqRate = RATE_W'(3000);
    @(negedge clk); reqValid = 1'b0;
    while (!done && n < 500) begin
      @(negedge clk); n++;
      if (n == 1) check(busDiv == 4, "R5", "pre-raise before timeout", busDiv, 4);
    end
    check(n == LOCK_CYC + 1, "R8", "timeout cycles", n, LOCK_CYC + 1);
    check(error && done, "R8", "error with done", {error, done}, 3);
    check(muxSel == oldSel, "R8", "select kept", muxSel, oldSel);
    check(busDiv == (DIV_W+1)'(oldDiv), "R8", "divisor restored", busDiv, oldDiv);
    @(negedge clk);
    check(!error && !done && !busy, "R8", "flags clear", {error, done, busy}, 0);
    neverLock = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testScaleUp();
    testScaleDown();
    testClampHigh();
    testSameRate();
    testClampLow();
    testRoundUp();
    testTimeout();
    testIgnoreBusy();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule